// File: doc/BRIEF.md
# Dual-Mode Loop Signature Register

This block is a register of parameterised width meant to sit on a feedback loop inside a datapath. In functional operation it behaves exactly like the plain register it replaces and captures its parallel input on every clock. In self-test operation the same flops fold the parallel input into a shifting linear-feedback state on every clock, so the register compacts the responses of the logic that feeds it. Its output keeps driving the logic downstream, and that logic receives the evolving state as pseudorandom stimulus in the same session. One register therefore serves as both pattern source and response compactor.

A serial path seeds the register before a self-test run and unloads the final signature afterwards. Each bit adds only an AND, a NOR and an XOR in front of the existing flop. Only bit 0 also has a two-way select: it takes either the feedback parity or the serial input.

The two-bit mode input selects one of four operating states. Any state may follow any other on the next clock, and synchronous reset overrides all of them.

| Code | State | Next-state rule |
|------|-------|-----------------|
| 2'b11 | LOAD | The parallel input is captured. |
| 2'b10 | SIGN | The parallel input is XORed into the shifted state, and the feedback parity enters bit 0. |
| 2'b00 | SHIFT | The serial input enters bit 0 and every bit moves up one place. |
| 2'b01 | CLEAR | The register is zeroed. |

Top module: `loop_sig_reg`

## Requirements
- R1: A synchronous active-high `rst` forces the register to all zeros on the next rising clock edge, whatever the mode and inputs.
- R2: In mode 2'b11 (LOAD), the register takes `par_in` on each rising edge.
- R3: In mode 2'b01 (CLEAR), the register becomes all zeros on the next edge, whatever `par_in` and `scan_in` are.
- R4: In mode 2'b00 (SHIFT), on each edge bit 0 takes `scan_in` and bit i takes the old bit i-1, and `par_in` has no effect. `scan_out` always shows the top bit, so a signature of WIDTH bits unloads most-significant bit first over WIDTH shifts.
- R5: In mode 2'b10 (SIGN), on each edge bit i (for i≥1) takes `par_in[i]` XOR old bit i-1. Bit 0 takes `par_in[0]` XOR the parity of the tapped old bits. For WIDTH=3 the taps are bits 2 and 1 (x^3+x^2+1). For WIDTH=10 the taps are bits 9 and 6 (x^10+x^7+1).
- R6: `par_out` equals the register state in every mode, so the downstream logic sees the test state as stimulus.
- R7: In SIGN mode with `par_in` held at zero, a non-zero state repeats for the first time after exactly 2^WIDTH-1 clocks: 7 clocks for WIDTH=3 and 1023 clocks for WIDTH=10.
- R8: Flipping a single `par_in` bit in any one clock of a SIGN run changes the final signature, and the changed signature still matches the R5 recurrence.
- R9: WIDTH is a parameter with supported values 2 to 12. Instances with WIDTH=3 and WIDTH=10 both follow R2 to R5 with their own taps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Operating state: 11 LOAD, 10 SIGN, 00 SHIFT, 01 CLEAR |
| par_in | input | WIDTH | Parallel data, which is the functional input or the response to compact |
| scan_in | input | 1 | Serial input used in SHIFT |
| par_out | output | WIDTH | Register state that drives the downstream logic |
| scan_out | output | 1 | Top bit of the state, used for serial unload |

## Verification
A fixed 3-bit vector walk covers every transition between modes. It uses hand-computed states, including SIGN steps where the input cancels the feedback to zero and SHIFT steps with a non-zero `par_in`, and so separates the tap choice, the chain direction and input leakage. A 10-bit run over 40 pseudorandom words is compared against a recurrence model. That run is then repeated with single-bit flips at the first, a middle and the last cycle and at low, middle and top bit positions, which exposes any lane that fails to reach the signature. Zero-input SIGN runs measure the full cycle length at both widths, so a wrong or missing tap would show as a short period. The signature is then unloaded serially and compared with the parallel value.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIGN  = 2'b10,
        MODE_LOAD  = 2'b11
    } lsr_mode_e;

    // Feedback tap mask: bit k set means state bit k feeds the parity.
    // Each entry is a primitive polynomial of the given degree.
    function automatic logic [31:0] lsr_tap_mask(input int width);
        logic [31:0] m;
        m = '0;
        case (width)
            2:       m = 32'h0000_0003;
            3:       m = 32'h0000_0006;
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0E08;
            default: m = 32'h0000_0001 << (width - 1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lsr_parity.sv
module lsr_parity #(
    parameter int          WIDTH = 3,
    parameter logic [31:0] TAPS  = 32'h6
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);
    localparam logic [WIDTH-1:0] MASK = TAPS[WIDTH-1:0];

    assign fb = ^(state & MASK);
endmodule

// File: rtl/lsr_bit.sv
module lsr_bit (
    input  logic data_en,
    input  logic chain_en,
    input  logic din,
    input  logic prev,
    output logic nxt
);
    logic gated_d;
    logic gated_c;

    assign gated_d = data_en & din;             // AND gate
    assign gated_c = ~(~prev | ~chain_en);      // NOR gate
    assign nxt     = gated_d ^ gated_c;         // XOR gate
endmodule

// File: rtl/loop_sig_reg.sv
module loop_sig_reg #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    import lsr_pkg::*;

    localparam logic [31:0]      TAP_FULL = lsr_tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAP_MASK = TAP_FULL[WIDTH-1:0];

    lsr_mode_e        mode;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic             data_en;
    logic             chain_en;
    logic             head_fb;
    logic             fb;
    logic             head;

    assign mode = lsr_mode_e'(mode_sel);

    // Mode decode: the per-bit gating controls for each operating state.
    always_comb begin
        data_en  = 1'b0;
        chain_en = 1'b0;
        head_fb  = 1'b0;
        unique case (mode)
            MODE_LOAD:  begin data_en = 1'b1; end
            MODE_SIGN:  begin data_en = 1'b1; chain_en = 1'b1; head_fb = 1'b1; end
            MODE_SHIFT: begin chain_en = 1'b1; end
            MODE_CLEAR: begin end
        endcase
    end

    lsr_parity #(.WIDTH(WIDTH), .TAPS(TAP_FULL)) u_parity (
        .state (state_q),
        .fb    (fb)
    );

    assign head = head_fb ? fb : scan_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prev;
        if (i == 0) begin : g_head
            assign prev = head;
        end else begin : g_chain
            assign prev = state_q[i-1];
        end
        lsr_bit u_bit (
            .data_en  (data_en),
            .chain_en (chain_en),
            .din      (par_in[i]),
            .prev     (prev),
            .nxt      (state_d[i])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // Outputs
    always_comb begin
        par_out  = state_q;
        scan_out = state_q[WIDTH-1];
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (par_out == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |=> (par_out == $past(par_in)));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |=> (par_out == '0));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)}));

    // R5
    sign_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10) |=>
            (par_out[WIDTH-1:1] == ($past(par_in[WIDTH-1:1]) ^ $past(par_out[WIDTH-2:0]))));

    // R5
    sign_head_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10) |=>
            (par_out[0] == ($past(par_in[0]) ^ (^($past(par_out) & TAP_MASK)))));

    // R4
    scan_top_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |=> (scan_out == $past(par_out[WIDTH-2])));
endmodule

// File: tb/loop_sig_reg_tb.sv
`timescale 1ns/1ps
module loop_sig_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] m3  = 2'b11;
    logic [2:0] d3  = '0;
    logic       si3 = 1'b0;
    logic [2:0] p3;
    logic       so3;
    logic [1:0] m10  = 2'b11;
    logic [9:0] d10  = '0;
    logic       si10 = 1'b0;
    logic [9:0] p10;
    logic       so10;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    loop_sig_reg u_dut (
        .clk(clk), .rst(rst), .mode_sel(m3), .par_in(d3), .scan_in(si3),
        .par_out(p3), .scan_out(so3)
    );

    loop_sig_reg #(.WIDTH(10)) u_dut10 (
        .clk(clk), .rst(rst), .mode_sel(m10), .par_in(d10), .scan_in(si10),
        .par_out(p10), .scan_out(so10)
    );

    // {mode[1:0], par_in[2:0], scan_in, expected state[2:0]}
    localparam int NV = 12;
    localparam logic [8:0] VEC [NV] = '{
        {2'b11, 3'b101, 1'b0, 3'b101},
        {2'b10, 3'b011, 1'b0, 3'b000},
        {2'b10, 3'b110, 1'b0, 3'b110},
        {2'b10, 3'b000, 1'b0, 3'b100},
        {2'b10, 3'b010, 1'b0, 3'b011},
        {2'b00, 3'b000, 1'b1, 3'b111},
        {2'b00, 3'b000, 1'b0, 3'b110},
        {2'b01, 3'b111, 1'b1, 3'b000},
        {2'b00, 3'b101, 1'b1, 3'b001},
        {2'b10, 3'b000, 1'b0, 3'b010},
        {2'b11, 3'b100, 1'b1, 3'b100},
        {2'b10, 3'b111, 1'b0, 3'b110}
    };

    localparam int         NRUN = 40;
    localparam logic [9:0] SEED = 10'h2A5;
    logic [9:0] dat [NRUN];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b11:   return "R2 load";
            2'b10:   return "R5 sign";
            2'b00:   return "R4 shift";
            default: return "R3 clear";
        endcase
    endfunction

    // Independent model of the 10-bit recurrence: taps at bits 9 and 6
    function automatic logic [9:0] ref10(input logic [9:0] q, input logic [9:0] d);
        return {q[8:0], q[9] ^ q[6]} ^ d;
    endfunction

    task automatic edge_wait;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run10(input int fc, input int fbit,
                         output logic [9:0] sig, output logic [9:0] mdl);
        logic [9:0] q;
        q   = SEED;
        m10 = 2'b11;
        d10 = SEED;
        edge_wait();
        for (int c = 0; c < NRUN; c++) begin
            logic [9:0] dd;
            dd = dat[c];
            if (c == fc) dd[fbit] = ~dd[fbit];
            m10 = 2'b10;
            d10 = dd;
            q   = ref10(q, dd);
            edge_wait();
        end
        sig = p10;
        mdl = q;
        m10 = 2'b11;
        d10 = '0;
    endtask

    initial begin
        logic [31:0] lcg;
        logic [9:0]  base_sig, base_mdl, sig, mdl, rd;
        int          cnt;

        lcg = 32'h1234_5678;
        for (int i = 0; i < NRUN; i++) begin
            lcg    = lcg * 32'd1664525 + 32'd1013904223;
            dat[i] = lcg[25:16];
        end

        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset state w3", p3, 0);
        chk("R1 reset state w10", p10, 0);
        rst = 1'b0;

        // Vector walk, 3-bit instance
        for (int v = 0; v < NV; v++) begin
            m3  = VEC[v][8:7];
            d3  = VEC[v][6:4];
            si3 = VEC[v][3];
            edge_wait();
            chk({mode_tag(VEC[v][8:7]), " R6 par_out"}, p3, VEC[v][2:0]);
            chk("R4 scan_out top bit", so3, VEC[v][2]);
        end

        // R1: reset wins over LOAD
        m3 = 2'b11; d3 = 3'b111; rst = 1'b1;
        edge_wait();
        chk("R1 reset over load", p3, 0);
        rst = 1'b0;
        edge_wait();
        chk("R2 load after reset", p3, 3'b111);

        // R7: period for 3 bits from seed 001
        m3 = 2'b11; d3 = 3'b001;
        edge_wait();
        m3 = 2'b10; d3 = 3'b000;
        for (int k = 1; k <= 7; k++) begin
            edge_wait();
            if (k < 7) chk("R7 no early repeat w3", p3 == 3'b001, 0);
            else       chk("R7 repeat at 7 w3", p3, 3'b001);
        end

        // R5 / R9: 10-bit signature against the model
        run10(-1, 0, base_sig, base_mdl);
        chk("R5 R9 signature w10", base_sig, base_mdl);

        // R8: single-bit flips at several cycles and lanes
        for (int t = 0; t < 4; t++) begin
            int fc, fbit;
            fc   = (t == 0) ? 0 : (t == 1) ? 17 : (t == 2) ? 39 : 25;
            fbit = (t == 0) ? 0 : (t == 1) ? 5  : (t == 2) ? 9  : 3;
            run10(fc, fbit, sig, mdl);
            chk("R8 flip matches model", sig, mdl);
            chk("R8 flip changes signature", sig != base_sig, 1);
        end

        // R4: serial unload of the baseline signature, MSB first
        run10(-1, 0, sig, mdl);
        m10 = 2'b00; si10 = 1'b0; d10 = 10'h3FF;
        rd  = '0;
        for (int b = 0; b < 10; b++) begin
            rd = {rd[8:0], so10};
            edge_wait();
        end
        chk("R4 serial unload w10", rd, base_sig);
        chk("R4 shift ignores par_in", p10, 0);

        // R3: clear on 10 bits
        m10 = 2'b11; d10 = 10'h155;
        edge_wait();
        m10 = 2'b01; d10 = 10'h3FF; si10 = 1'b1;
        edge_wait();
        chk("R3 clear w10", p10, 0);

        // R7: period for 10 bits from seed 1
        m10 = 2'b11; d10 = 10'h001;
        edge_wait();
        m10 = 2'b10; d10 = '0;
        cnt = 0;
        do begin
            edge_wait();
            cnt++;
        end while (p10 != 10'h001 && cnt < 1100);
        chk("R7 period w10", cnt, 1023);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule